// File: doc/BRIEF.md
# SD Card SPI-Mode Data Block Engine

This block moves a single data block between a local byte buffer and an SD card running in SPI mode. It starts only after a separate command issuer has sent a read or write command and the card has accepted it. The engine sees the SPI link as a byte-exchange service. For every byte it raises a request with the byte to send, and the service answers with an acknowledge and the byte it received at the same moment.

On a write, the engine sends the start token. It then reads the payload from the buffer and sends it, followed by the CRC16 of the payload. After that it waits for the card's data response token and decodes it. When the card accepts the data, the engine keeps sending idle bytes through the card's busy period. On a read, the engine sends idle bytes until a start token or an error token arrives. It then writes the received payload into the buffer and compares the received CRC16 with its own.

Each transfer ends with a one-cycle completion pulse and a status code. A high-capacity flag forces the payload length to 512 bytes. Two byte-count limits bound the waiting phases.

Top module: `sd_blk_xfer`

## Requirements
- R1: After reset, `busy`, `done`, `xchg_req` and `buf_we` are low and `status` is 0.
- R2: A write sends exactly these bytes, in this order: 0xFE, then buffer bytes 0 to len-1, then CRC high byte, then CRC low byte. After that it sends 0xFF for every later byte of the transfer.
- R3: The CRC is CRC16 with polynomial 0x1021 and an initial value of 0. It is computed over the payload bytes only, MSB first.
- R4: After the CRC, the write waits for the response token and treats each 0xFF byte as idle. The first other byte is decoded by its bits [3:1]:
  - 010: the card accepted the data and the busy phase starts.
  - 101: status 2.
  - 110: status 3.
  - any other value: status 6.
  If WAIT_MAX idle bytes arrive with no token, the status is 5.
- R5: In the busy phase, each 0x00 byte means the card is still busy. The first non-zero byte ends the transfer with status 0. If BUSY_MAX zero bytes arrive in a row, the status is 5.
- R6: While a read waits for its start token:
  - 0xFE starts the payload.
  - A byte with bits [7:4] equal to 0 is an error token. It ends the transfer with status 4, puts bits [3:0] on `err_code` and writes nothing to the buffer.
  - Every other byte is ignored.
- R7: A read stores the payload bytes in arrival order at buffer addresses 0 to len-1, one `buf_we` pulse per byte. All bytes the engine sends during a read are 0xFF.
- R8: A read compares the two trailing bytes (high byte first) with the CRC16 of the received payload. A match gives status 0. A mismatch gives status 1, and the payload is still stored.
- R9: If a read receives WAIT_MAX ignored bytes while waiting for its token, it ends with status 5 after exactly WAIT_MAX exchanges.
- R10: The payload length is sampled at `start`. It is 512 when `high_cap` is set, whatever `blk_len` holds. Otherwise it is `blk_len`, which must be in the range 1 to 512.
- R11: `done` is a one-cycle pulse, and `busy` is low in the same cycle. `status` holds until the next accepted `start`. A `start` given while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| wr_mode | input | 1 | 1 = write block to card, 0 = read block |
| high_cap | input | 1 | High-capacity card: payload fixed to 512 bytes |
| blk_len | input | 10 | Programmed block length, 1 to 512 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 ok, 1 CRC mismatch, 2 rejected CRC, 3 rejected write, 4 error token, 5 timeout, 6 bad response |
| err_code | output | 4 | Low nibble of the received error token |
| xchg_req | output | 1 | Byte exchange request |
| xchg_tx | output | 8 | Byte to send while the request is high |
| xchg_ack | input | 1 | Exchange complete; `xchg_rx` is valid |
| xchg_rx | input | 8 | Byte received by the exchange |
| buf_addr | output | 9 | Buffer byte address |
| buf_rdata | input | 8 | Buffer read data for `buf_addr` (combinational) |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |

## Verification
The assertions check the following on every cycle:
- `done` is a single-cycle pulse and `busy` is low while it is high.
- `status` does not move between transfers.
- Buffer writes always fall inside the sampled block length.
- Neither wait counter ever reaches its limit as a stored value.

Only the bench scenarios can show the exact byte order on the link, the CRC values, the decoding of each response code, the ignored bytes before a start token, and the exchange counts at which timeouts fire. The bench checks these against scripted card replies under random acknowledge delays.

// File: rtl/sd_blk_pkg.sv
package sd_blk_pkg;
  localparam logic [7:0] TOKEN_START = 8'hFE;
  localparam logic [7:0] BYTE_IDLE   = 8'hFF;

  typedef enum logic [2:0] {
    XS_OK       = 3'd0,
    XS_CRC_BAD  = 3'd1,
    XS_REJ_CRC  = 3'd2,
    XS_REJ_WR   = 3'd3,
    XS_ERR_TOK  = 3'd4,
    XS_TIMEOUT  = 3'd5,
    XS_BAD_RESP = 3'd6
  } xfer_status_e;

  typedef enum logic [3:0] {
    PH_IDLE, PH_W_TOK, PH_W_DATA, PH_W_CRC_H, PH_W_CRC_L, PH_W_RESP,
    PH_W_BUSY, PH_R_WAIT, PH_R_DATA, PH_R_CRC_H, PH_R_CRC_L
  } phase_e;
endpackage

// File: rtl/sd_crc16_acc.sv
module sd_crc16_acc #(
  parameter logic [15:0] POLY = 16'h1021
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  logic [15:0] crc_q, crc_step, crc_d;

  always_comb begin
    crc_step = crc_q;
    for (int i = 7; i >= 0; i--) begin
      if (crc_step[15] ^ din[i]) crc_step = {crc_step[14:0], 1'b0} ^ POLY;
      else                       crc_step = {crc_step[14:0], 1'b0};
    end
  end

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = '0;
    else if (en) crc_d = crc_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/sd_wait_timer.sv
module sd_wait_timer #(
  parameter int MAX = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic expired
);
  localparam int W = $clog2(MAX + 1);
  logic [W-1:0] cnt_q, cnt_d;

  assign expired = tick && (cnt_q == W'(MAX - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                   cnt_d = '0;
    else if (tick && !expired) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5 R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < W'(MAX));
endmodule

// File: rtl/sd_blk_xfer.sv
module sd_blk_xfer
  import sd_blk_pkg::*;
#(
  parameter int MAX_BLK  = 512,
  parameter int WAIT_MAX = 1024,
  parameter int BUSY_MAX = 65536,
  localparam int LEN_W   = $clog2(MAX_BLK + 1),
  localparam int AW      = $clog2(MAX_BLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wr_mode,
  input  logic             high_cap,
  input  logic [LEN_W-1:0] blk_len,
  output logic             busy,
  output logic             done,
  output logic [2:0]       status,
  output logic [3:0]       err_code,
  output logic             xchg_req,
  output logic [7:0]       xchg_tx,
  input  logic             xchg_ack,
  input  logic [7:0]       xchg_rx,
  output logic [AW-1:0]    buf_addr,
  input  logic [7:0]       buf_rdata,
  output logic             buf_we,
  output logic [7:0]       buf_wdata
);
  phase_e         ph_q, ph_d;
  logic [LEN_W-1:0] len_q, len_d, idx_q, idx_d;
  logic [7:0]     hi_q, hi_d, wdata_q, wdata_d;
  logic [AW-1:0]  waddr_q, waddr_d;
  logic           we_q, we_d, done_q, done_d;
  xfer_status_e   st_q, st_d;
  logic [3:0]     err_q, err_d;

  logic        fire, accept, last, crc_en;
  logic [7:0]  crc_din;
  logic [15:0] crc;
  logic        rd_hold, resp_hold, busy_hold;
  logic        wait_tick, busy_tick, wait_exp, busy_exp;

  assign fire   = xchg_req && xchg_ack;
  assign accept = (ph_q == PH_IDLE) && start;
  assign last   = (idx_q == len_q - 1'b1);

  assign rd_hold   = (xchg_rx != TOKEN_START) && (xchg_rx[7:4] != 4'h0);
  assign resp_hold = (xchg_rx == BYTE_IDLE);
  assign busy_hold = (xchg_rx == 8'h00);
  assign wait_tick = fire && (((ph_q == PH_R_WAIT) && rd_hold) ||
                              ((ph_q == PH_W_RESP) && resp_hold));
  assign busy_tick = fire && (ph_q == PH_W_BUSY) && busy_hold;

  assign crc_en  = fire && ((ph_q == PH_W_DATA) || (ph_q == PH_R_DATA));
  assign crc_din = (ph_q == PH_W_DATA) ? buf_rdata : xchg_rx;

  sd_crc16_acc #(.POLY(16'h1021)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(crc_en), .din(crc_din), .crc(crc)
  );

  sd_wait_timer #(.MAX(WAIT_MAX)) u_wait_tmr (
    .clk(clk), .rst_n(rst_n), .clr(accept), .tick(wait_tick), .expired(wait_exp)
  );

  sd_wait_timer #(.MAX(BUSY_MAX)) u_busy_tmr (
    .clk(clk), .rst_n(rst_n), .clr(accept), .tick(busy_tick), .expired(busy_exp)
  );

  always_comb begin
    case (ph_q)
      PH_W_TOK:   xchg_tx = TOKEN_START;
      PH_W_DATA:  xchg_tx = buf_rdata;
      PH_W_CRC_H: xchg_tx = crc[15:8];
      PH_W_CRC_L: xchg_tx = crc[7:0];
      default:    xchg_tx = BYTE_IDLE;
    endcase
  end

  always_comb begin
    ph_d    = ph_q;
    len_d   = len_q;
    idx_d   = idx_q;
    hi_d    = hi_q;
    st_d    = st_q;
    err_d   = err_q;
    done_d  = 1'b0;
    we_d    = 1'b0;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    case (ph_q)
      PH_IDLE: if (start) begin
        ph_d  = wr_mode ? PH_W_TOK : PH_R_WAIT;
        len_d = high_cap ? LEN_W'(MAX_BLK) : blk_len;
        idx_d = '0;
        st_d  = XS_OK;
        err_d = '0;
      end
      PH_W_TOK: if (fire) ph_d = PH_W_DATA;
      PH_W_DATA: if (fire) begin
        idx_d = idx_q + 1'b1;
        if (last) ph_d = PH_W_CRC_H;
      end
      PH_W_CRC_H: if (fire) ph_d = PH_W_CRC_L;
      PH_W_CRC_L: if (fire) ph_d = PH_W_RESP;
      PH_W_RESP: if (fire) begin
        if (resp_hold) begin
          if (wait_exp) begin ph_d = PH_IDLE; done_d = 1'b1; st_d = XS_TIMEOUT; end
        end else begin
          case (xchg_rx[3:1])
            3'b010:  ph_d = PH_W_BUSY;
            3'b101:  begin ph_d = PH_IDLE; done_d = 1'b1; st_d = XS_REJ_CRC; end
            3'b110:  begin ph_d = PH_IDLE; done_d = 1'b1; st_d = XS_REJ_WR; end
            default: begin ph_d = PH_IDLE; done_d = 1'b1; st_d = XS_BAD_RESP; end
          endcase
        end
      end
      PH_W_BUSY: if (fire) begin
        if (!busy_hold) begin ph_d = PH_IDLE; done_d = 1'b1; st_d = XS_OK; end
        else if (busy_exp) begin ph_d = PH_IDLE; done_d = 1'b1; st_d = XS_TIMEOUT; end
      end
      PH_R_WAIT: if (fire) begin
        if (xchg_rx == TOKEN_START) ph_d = PH_R_DATA;
        else if (xchg_rx[7:4] == 4'h0) begin
          ph_d = PH_IDLE; done_d = 1'b1; st_d = XS_ERR_TOK; err_d = xchg_rx[3:0];
        end else if (wait_exp) begin
          ph_d = PH_IDLE; done_d = 1'b1; st_d = XS_TIMEOUT;
        end
      end
      PH_R_DATA: if (fire) begin
        we_d    = 1'b1;
        waddr_d = idx_q[AW-1:0];
        wdata_d = xchg_rx;
        idx_d   = idx_q + 1'b1;
        if (last) ph_d = PH_R_CRC_H;
      end
      PH_R_CRC_H: if (fire) begin hi_d = xchg_rx; ph_d = PH_R_CRC_L; end
      PH_R_CRC_L: if (fire) begin
        ph_d   = PH_IDLE;
        done_d = 1'b1;
        st_d   = ({hi_q, xchg_rx} == crc) ? XS_OK : XS_CRC_BAD;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      len_q   <= '0;
      idx_q   <= '0;
      hi_q    <= '0;
      st_q    <= XS_OK;
      err_q   <= '0;
      done_q  <= 1'b0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      ph_q    <= ph_d;
      len_q   <= len_d;
      idx_q   <= idx_d;
      hi_q    <= hi_d;
      st_q    <= st_d;
      err_q   <= err_d;
      done_q  <= done_d;
      we_q    <= we_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
    end
  end

  assign busy      = (ph_q != PH_IDLE);
  assign xchg_req  = busy;
  assign done      = done_q;
  assign status    = st_q;
  assign err_code  = err_q;
  assign buf_we    = we_q;
  assign buf_wdata = wdata_q;
  assign buf_addr  = we_q ? waddr_q : idx_q[AW-1:0];

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R11
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(status));
  // R7
  we_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (LEN_W'(buf_addr) < len_q));
endmodule

// File: tb/sd_blk_xfer_tb.sv
module sd_blk_xfer_tb;
  localparam int WMAX = 24;
  localparam int BMAX = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wr_mode = 1'b0, high_cap = 1'b0;
  logic [9:0] blk_len = 10'd8;
  logic busy, done, xchg_req, xchg_ack = 1'b0, buf_we;
  logic [2:0] status;
  logic [3:0] err_code;
  logic [7:0] xchg_tx, xchg_rx = 8'hFF, buf_rdata, buf_wdata;
  logic [8:0] buf_addr;

  logic [7:0] wmem [0:511];
  logic [7:0] rmem [0:511];
  logic [7:0] script [0:1199];
  logic [7:0] txlog [0:1199];
  int n_x, n_we, checks, fails, cycles;

  always #5 clk = ~clk;

  sd_blk_xfer #(.MAX_BLK(512), .WAIT_MAX(WMAX), .BUSY_MAX(BMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_mode(wr_mode), .high_cap(high_cap),
    .blk_len(blk_len), .busy(busy), .done(done), .status(status), .err_code(err_code),
    .xchg_req(xchg_req), .xchg_tx(xchg_tx), .xchg_ack(xchg_ack), .xchg_rx(xchg_rx),
    .buf_addr(buf_addr), .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_wdata(buf_wdata)
  );

  assign buf_rdata = wmem[buf_addr];

  function automatic logic [15:0] crc_bits(input logic [15:0] c, input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[15] ^ b[i];
      c = c << 1;
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // card side: acknowledge with random delay, log sent bytes
  initial begin
    forever begin
      @(negedge clk);
      if (xchg_ack) xchg_ack = 1'b0;
      else if (xchg_req && ($urandom_range(0, 2) != 0)) begin
        xchg_rx = (n_x < 1200) ? script[n_x] : 8'hFF;
        if (n_x < 1200) txlog[n_x] = xchg_tx;
        n_x++;
        xchg_ack = 1'b1;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (buf_we) begin rmem[buf_addr] = buf_wdata; n_we++; end
    end
  end

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  task automatic clear_script();
    for (int i = 0; i < 1200; i++) script[i] = 8'hFF;
    n_x = 0; n_we = 0;
  endtask

  task automatic go(input bit wr, input bit hc, input int bl);
    @(negedge clk);
    wr_mode = wr; high_cap = hc; blk_len = 10'(bl); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  // write: payload in wmem, card answers after pre idle bytes
  task automatic do_write(input int len, input int pre, input logic [7:0] tok,
                          input int nz, input int exp_st, input string tag);
    logic [15:0] c;
    int base, bad, exp_n;
    clear_script();
    c = 16'h0;
    for (int i = 0; i < len; i++) begin
      wmem[i] = 8'($urandom);
      c = crc_bits(c, wmem[i]);
    end
    base = len + 3;
    for (int i = 0; i < pre; i++) script[base + i] = 8'hFF;
    script[base + pre] = tok;
    for (int i = 0; i < nz; i++) script[base + pre + 1 + i] = 8'h00;
    script[base + pre + 1 + nz] = 8'h80;
    go(1'b1, 1'b0, len);
    bad = 0;
    if (txlog[0] != 8'hFE) bad++;
    for (int i = 0; i < len; i++) if (txlog[1 + i] != wmem[i]) bad++;
    chk(bad == 0, {tag, " R2 frame"}, bad, 0);
    chk({txlog[len + 1], txlog[len + 2]} == c, {tag, " R3 crc"},
        int'({txlog[len + 1], txlog[len + 2]}), int'(c));
    chk(status == 3'(exp_st), {tag, " R4 status"}, status, exp_st);
    if (exp_st == 0) exp_n = base + pre + 1 + nz + 1;
    else if (exp_st == 5 && tok == 8'hE5) exp_n = base + pre + 1 + BMAX;
    else exp_n = base + pre + 1;
    chk(n_x == exp_n, {tag, " R5 exchanges"}, n_x, exp_n);
  endtask

  // read: junk bytes then token, payload, crc (optionally corrupted)
  task automatic do_read(input int len, input bit hc, input int bl, input int pre,
                         input bit corrupt, input string tag);
    logic [15:0] c;
    logic [7:0] expd [0:511];
    int bad, badtx;
    clear_script();
    c = 16'h0;
    for (int i = 0; i < pre; i++) script[i] = (i % 2) ? 8'h7F : 8'hFF;
    script[pre] = 8'hFE;
    for (int i = 0; i < len; i++) begin
      expd[i] = 8'($urandom);
      script[pre + 1 + i] = expd[i];
      c = crc_bits(c, expd[i]);
    end
    if (corrupt) c = c ^ 16'h0100;
    script[pre + 1 + len] = c[15:8];
    script[pre + 2 + len] = c[7:0];
    go(1'b0, hc, bl);
    bad = 0;
    for (int i = 0; i < len; i++) if (rmem[i] !== expd[i]) bad++;
    chk(bad == 0 && n_we == len, {tag, " R7 stored"}, n_we, len);
    badtx = 0;
    for (int i = 0; i < n_x; i++) if (txlog[i] != 8'hFF) badtx++;
    chk(badtx == 0, {tag, " R7 idle tx"}, badtx, 0);
    chk(status == (corrupt ? 3'd1 : 3'd0), {tag, " R8 status"}, status, corrupt ? 1 : 0);
    chk(n_x == pre + len + 3, {tag, " R6 exchanges"}, n_x, pre + len + 3);
  endtask

  initial begin
    int sel, ln;
    void'($urandom(32'd7));
    checks = 0; fails = 0;
    clear_script();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !xchg_req && !buf_we && status == 0, "R1 reset", status, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !xchg_req, "R1 after release", busy, 0);

    do_write(8, 2, 8'hE5, 3, 0, "wr_ok");
    do_write(5, 0, 8'h0B, 0, 2, "wr_rej_crc");
    do_write(5, 1, 8'h0D, 0, 3, "wr_rej_wr");
    do_write(4, 0, 8'h07, 0, 6, "wr_bad_resp");
    do_write(3, 0, 8'hE5, 40, 5, "R5 busy_tmo");
    do_write(1, 0, 8'hE5, 0, 0, "R10 len1");
    do_write(512, 0, 8'hE5, 1, 0, "R10 len512");

    // R4 response wait timeout: no token at all
    clear_script();
    for (int i = 0; i < 4; i++) wmem[i] = 8'(i);
    go(1'b1, 1'b0, 4);
    chk(status == 3'd5 && n_x == 7 + WMAX, "R4 resp_tmo", n_x, 7 + WMAX);

    do_read(16, 1'b0, 16, 3, 1'b0, "rd_ok");
    do_read(9, 1'b0, 9, 0, 1'b1, "rd_crcbad");
    do_read(512, 1'b1, 5, 1, 1'b0, "R10 hc");

    // R6 error token
    clear_script();
    script[0] = 8'hFF; script[1] = 8'h7F; script[2] = 8'h09;
    go(1'b0, 1'b0, 8);
    chk(status == 3'd4 && err_code == 4'h9, "R6 err_token", err_code, 9);
    chk(n_we == 0 && n_x == 3, "R6 no_store", n_we, 0);

    // R9 read wait timeout
    clear_script();
    go(1'b0, 1'b0, 8);
    chk(status == 3'd5 && n_x == WMAX, "R9 rd_tmo", n_x, WMAX);

    // R11 done pulse, status hold, start ignored while busy
    repeat (3) @(negedge clk);
    chk(!done && status == 3'd5, "R11 hold", status, 5);
    clear_script();
    for (int i = 0; i < 6; i++) wmem[i] = 8'(i + 3);
    script[9] = 8'hE5; script[10] = 8'h80;
    @(negedge clk);
    wr_mode = 1'b1; blk_len = 10'd6; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    wr_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk(status == 3'd0 && n_x == 11 && txlog[0] == 8'hFE, "R11 start_ignored", n_x, 11);
    @(negedge clk);
    chk(!done, "R11 pulse", done, 0);

    // random mix
    for (int k = 0; k < 6; k++) begin
      sel = $urandom_range(0, 1);
      ln = $urandom_range(1, 64);
      if (sel == 1) do_write(ln, $urandom_range(0, 3), 8'hE5, $urandom_range(0, 5), 0, "rnd_wr");
      else do_read(ln, 1'b0, ln, $urandom_range(0, 5), 1'b0, "rnd_rd");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule